// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

The router serves a cluster of cores. Each core owns seven private interrupt sources. For every core it keeps a copy of the raw source levels, taken one clock late, and an enable mask. It also holds one destination register per source, which steers that source onto one of the core's interrupt pins. A core's pin is high while at least one enabled, pending source is steered to it.

Software reaches the registers through a small word-addressed port. Each access carries the number of the issuing core and a window flag. The direct window reaches the issuing core's own registers. The remote window reaches the registers of the core named in the issuing core's remote-index register. This lets one core set up the masks and destinations of every other core.

Hardware straps decide which sources may be steered. A source that may not be steered ignores its destination register and always lands on a fixed default pin.

Top module: `local_irq_router`

## Requirements
- R1: The source bits of a core sit in this fixed order: bit 0 watchdog, bit 1 compare, bit 2 timer, bit 3 performance counter, bit 4 software 0, bit 5 software 1, bit 6 fast debug channel. The pending register (address 1) reads back the core's source levels as they were sampled at the previous clock edge.
- R2: The enable mask reads at address 2. A write to address 3 sets every mask bit that has a one in the data. A write to address 4 clears every mask bit that has a one in the data. Zero data bits leave the mask unchanged.
- R3: After reset, the following registers read zero and every pin output is low: every mask, every pending register, every destination register and every remote-index register.
- R4: A pin is high only while some source of that core is pending, enabled and steered to that pin. Several such sources on one pin are ORed together. The pin follows a source change one clock after the change.
- R5: The destination register of source j sits at address 8+j. Bit 31 is a valid flag and bits [PIN_W-1:0] hold the pin number. A steerable source whose valid flag is clear, or whose pin number is not below NUM_PINS, drives no pin.
- R6: The control register (address 0) returns the core's strap bits. Bit 0 is timer, bit 1 is performance counter, bit 2 is fast debug channel and bit 3 is shared by both software sources. Watchdog and compare are always steerable.
- R7: A source whose strap bit is clear ignores its destination register and drives pin DEFAULT_PIN (0 by default). The destination register stays readable and writable.
- R8: With busOther low, an access targets busCore. With busOther high, it targets the core held in busCore's remote-index register (address 5). That register is reachable only through the direct window: in the remote window it reads zero and ignores writes.
- R9: Reads of unused addresses (6, 7 and 15) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | NUM_CORES*7 | Raw source levels, core c at bits [c*7 +: 7] |
| routeStrap | input | NUM_CORES*4 | Steerable straps, core c at bits [c*4 +: 4] |
| busCore | input | CORE_W | Issuing core of the access |
| busOther | input | 1 | 0 selects the direct window, 1 the remote window |
| busWe | input | 1 | Write strobe |
| busAddr | input | 4 | Register word address |
| busWData | input | DATA_W | Write data |
| busRData | output | DATA_W | Read data, combinational from address and window |
| coreIrq | output | NUM_CORES*NUM_PINS | Pin outputs, core c at bits [c*NUM_PINS +: NUM_PINS] |

## Verification
Some properties are checked on every cycle:
- The pending copy tracks the source levels.
- Direct-window set and clear writes take effect on the issuing core's mask.
- Masks are clear right after reset.
- No pin rises without an enabled, pending source on that core.

Other behaviours can only be shown by directed scenarios, because they depend on register contents that the bench sets up:
- The choice of pin through the destination registers, and the rejection of invalid or out-of-range pins.
- The fallback to the default pin when a strap bit is clear, including the shared software strap.
- The way remote-window accesses reach another core without disturbing the issuer.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int NUM_SRC = 7;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PEND = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd5;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_PEND, RD_MASK, RD_SEL, RD_MAP
  } lirRd_e;

  typedef struct packed {
    logic       maskSet;
    logic       maskClr;
    logic       mapWr;
    logic       selWr;
    logic [2:0] srcIdx;
    lirRd_e     rdSel;
  } lirStrobe_t;

  // strap bits: 0 timer, 1 perf counter, 2 debug channel, 3 software pair
  function automatic logic srcRoutable(input int j, input logic [3:0] strap);
    case (j)
      2:       return strap[0];
      3:       return strap[1];
      4, 5:    return strap[3];
      6:       return strap[2];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/lir_ctrl.sv
module lir_ctrl
  import lir_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input  logic [CORE_W-1:0] busCore,
  input  logic              busOther,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CORE_W-1:0] issuerSel,
  output logic [CORE_W-1:0] tgtCore,
  output lirStrobe_t        strb
);
  always_comb begin
    tgtCore = busOther ? issuerSel : busCore;
    strb = '0;
    strb.rdSel = RD_NONE;
    strb.srcIdx = busAddr[2:0];
    if (busAddr[3]) begin
      if (busAddr[2:0] != 3'd7) begin
        strb.rdSel = RD_MAP;
        strb.mapWr = busWe;
      end
    end else begin
      case (busAddr)
        A_CTL:  strb.rdSel = RD_CTL;
        A_PEND: strb.rdSel = RD_PEND;
        A_MASK: strb.rdSel = RD_MASK;
        A_SET:  strb.maskSet = busWe;
        A_CLR:  strb.maskClr = busWe;
        A_SEL: begin
          if (!busOther) begin
            strb.rdSel = RD_SEL;
            strb.selWr = busWe;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lir_datapath.sv
module lir_datapath
  import lir_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_PINS    = 6,
  parameter int DATA_W      = 32,
  parameter int DEFAULT_PIN = 0,
  parameter int CORE_W      = 2,
  parameter int PIN_W       = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES*NUM_SRC-1:0]  srcLevel,
  input  logic [NUM_CORES*4-1:0]        routeStrap,
  input  logic [CORE_W-1:0]             tgtCore,
  input  logic [CORE_W-1:0]             issuerCore,
  input  lirStrobe_t                    strb,
  input  logic [DATA_W-1:0]             wData,
  output logic [DATA_W-1:0]             rData,
  output logic [CORE_W-1:0]             issuerSel,
  output logic [NUM_CORES*NUM_PINS-1:0] coreIrq,
  output logic [NUM_CORES*NUM_SRC-1:0]  maskFlat,
  output logic [NUM_CORES*NUM_SRC-1:0]  pendFlat
);
  localparam int TOT_SRC = NUM_CORES * NUM_SRC;

  logic [NUM_CORES*CORE_W-1:0] selFlat;
  logic [TOT_SRC-1:0]          vldFlat;
  logic [TOT_SRC*PIN_W-1:0]    pinFlat;
  logic                        unusedData;

  assign unusedData = ^wData;

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [NUM_SRC-1:0] maskQ;
    logic [NUM_SRC-1:0] pendQ;
    logic [NUM_SRC-1:0] vldQ;
    logic [PIN_W-1:0]   pinQ [NUM_SRC];
    logic [CORE_W-1:0]  selQ;
    logic [NUM_PINS-1:0] irqV;
    logic               hitMe;

    assign hitMe = (tgtCore == CORE_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= '0;
        pendQ <= '0;
        vldQ  <= '0;
        selQ  <= '0;
        for (int j = 0; j < NUM_SRC; j++) pinQ[j] <= '0;
      end else begin
        pendQ <= srcLevel[c*NUM_SRC +: NUM_SRC];
        if (hitMe) begin
          if (strb.maskSet) maskQ <= maskQ | wData[NUM_SRC-1:0];
          else if (strb.maskClr) maskQ <= maskQ & ~wData[NUM_SRC-1:0];
          if (strb.mapWr) begin
            vldQ[strb.srcIdx] <= wData[DATA_W-1];
            pinQ[strb.srcIdx] <= wData[PIN_W-1:0];
          end
          if (strb.selWr) selQ <= wData[CORE_W-1:0];
        end
      end
    end

    // pin decode: steerable sources follow their destination, others the default pin
    always_comb begin
      irqV = '0;
      for (int j = 0; j < NUM_SRC; j++) begin
        if (pendQ[j] && maskQ[j]) begin
          if (srcRoutable(j, routeStrap[c*4 +: 4])) begin
            if (vldQ[j] && (int'(pinQ[j]) < NUM_PINS)) irqV[pinQ[j]] = 1'b1;
          end else begin
            irqV[DEFAULT_PIN] = 1'b1;
          end
        end
      end
    end

    assign coreIrq[c*NUM_PINS +: NUM_PINS] = irqV;
    assign maskFlat[c*NUM_SRC +: NUM_SRC]  = maskQ;
    assign pendFlat[c*NUM_SRC +: NUM_SRC]  = pendQ;
    assign vldFlat[c*NUM_SRC +: NUM_SRC]   = vldQ;
    assign selFlat[c*CORE_W +: CORE_W]     = selQ;
    for (genvar j = 0; j < NUM_SRC; j++) begin : gPin
      assign pinFlat[(c*NUM_SRC+j)*PIN_W +: PIN_W] = pinQ[j];
    end
  end

  assign issuerSel = selFlat[int'(issuerCore)*CORE_W +: CORE_W];

  always_comb begin
    int srcPos;
    srcPos = int'(tgtCore) * NUM_SRC + int'(strb.srcIdx);
    rData = '0;
    case (strb.rdSel)
      RD_CTL:  rData[3:0] = routeStrap[int'(tgtCore)*4 +: 4];
      RD_PEND: rData[NUM_SRC-1:0] = pendFlat[int'(tgtCore)*NUM_SRC +: NUM_SRC];
      RD_MASK: rData[NUM_SRC-1:0] = maskFlat[int'(tgtCore)*NUM_SRC +: NUM_SRC];
      RD_SEL:  rData[CORE_W-1:0] = selFlat[int'(tgtCore)*CORE_W +: CORE_W];
      RD_MAP: begin
        rData[DATA_W-1]  = vldFlat[srcPos];
        rData[PIN_W-1:0] = pinFlat[srcPos*PIN_W +: PIN_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
  import lir_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_PINS    = 6,
  parameter int DATA_W      = 32,
  parameter int DEFAULT_PIN = 0,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES*NUM_SRC-1:0]  srcLevel,
  input  logic [NUM_CORES*4-1:0]        routeStrap,
  input  logic [CORE_W-1:0]             busCore,
  input  logic                          busOther,
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWData,
  output logic [DATA_W-1:0]             busRData,
  output logic [NUM_CORES*NUM_PINS-1:0] coreIrq
);
  logic [CORE_W-1:0]            tgtCore;
  logic [CORE_W-1:0]            issuerSel;
  lirStrobe_t                   strb;
  logic [NUM_CORES*NUM_SRC-1:0] maskFlat;
  logic [NUM_CORES*NUM_SRC-1:0] pendFlat;

  lir_ctrl #(.CORE_W(CORE_W)) uCtrl (
    .busCore  (busCore),
    .busOther (busOther),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .issuerSel(issuerSel),
    .tgtCore  (tgtCore),
    .strb     (strb)
  );

  lir_datapath #(
    .NUM_CORES  (NUM_CORES),
    .NUM_PINS   (NUM_PINS),
    .DATA_W     (DATA_W),
    .DEFAULT_PIN(DEFAULT_PIN),
    .CORE_W     (CORE_W),
    .PIN_W      (PIN_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .srcLevel  (srcLevel),
    .routeStrap(routeStrap),
    .tgtCore   (tgtCore),
    .issuerCore(busCore),
    .strb      (strb),
    .wData     (busWData),
    .rData     (busRData),
    .issuerSel (issuerSel),
    .coreIrq   (coreIrq),
    .maskFlat  (maskFlat),
    .pendFlat  (pendFlat)
  );
endmodule

// File: rtl/local_irq_router_chk.sv
module local_irq_router_chk
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [CORE_W-1:0]             busCore,
  input logic                          busOther,
  input logic                          busWe,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busWData,
  input logic [NUM_CORES*NUM_SRC-1:0]  srcLevel,
  input logic [NUM_CORES*NUM_SRC-1:0]  maskFlat,
  input logic [NUM_CORES*NUM_SRC-1:0]  pendFlat,
  input logic [NUM_CORES*NUM_PINS-1:0] coreIrq
);
  logic afterRst;
  logic unusedChk;

  assign unusedChk = ^busWData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) afterRst <= 1'b1;
    else       afterRst <= 1'b0;
  end

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    afterRst |-> (maskFlat == '0)); // R3

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendFlat == $past(srcLevel))); // R1

  for (genvar c = 0; c < NUM_CORES; c++) begin : gChk
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && !busOther && busAddr == A_SET && busCore == CORE_W'(c))
      |=> ((maskFlat[c*NUM_SRC +: NUM_SRC] & $past(busWData[NUM_SRC-1:0]))
           == $past(busWData[NUM_SRC-1:0]))); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && !busOther && busAddr == A_CLR && busCore == CORE_W'(c))
      |=> ((maskFlat[c*NUM_SRC +: NUM_SRC] & $past(busWData[NUM_SRC-1:0])) == '0)); // R2

    AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
      (coreIrq[c*NUM_PINS +: NUM_PINS] != '0)
      |-> ((pendFlat[c*NUM_SRC +: NUM_SRC] & maskFlat[c*NUM_SRC +: NUM_SRC]) != '0)); // R4
  end
endmodule

bind local_irq_router local_irq_router_chk #(
  .NUM_CORES(NUM_CORES),
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .CORE_W   (CORE_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busCore (busCore),
  .busOther(busOther),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWData(busWData),
  .srcLevel(srcLevel),
  .maskFlat(maskFlat),
  .pendFlat(pendFlat),
  .coreIrq (coreIrq)
);

// File: tb/local_irq_router_test.sv
`timescale 1ns/1ps
module local_irq_router_test;
  localparam int NC = 4;
  localparam int NP = 6;
  localparam int NS = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NC*NS-1:0] srcLevel = '0;
  logic [NC*4-1:0]  routeStrap = '0;
  logic [1:0]     busCore = '0;
  logic           busOther = 1'b0;
  logic           busWe = 1'b0;
  logic [3:0]     busAddr = '0;
  logic [31:0]    busWData = '0;
  logic [31:0]    busRData;
  logic [NC*NP-1:0] coreIrq;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  local_irq_router uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .routeStrap(routeStrap),
    .busCore(busCore), .busOther(busOther), .busWe(busWe), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .coreIrq(coreIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    srcLevel = '0;
    busWe = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input int core, input logic other, input logic [3:0] addr,
                          input logic [31:0] data);
    @(negedge clk);
    busCore = 2'(core); busOther = other; busAddr = addr; busWData = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int core, input logic other, input logic [3:0] addr,
                         output logic [31:0] data);
    busCore = 2'(core); busOther = other; busAddr = addr; busWe = 1'b0;
    #1;
    data = busRData;
  endtask

  task automatic setSrc(input int core, input logic [NS-1:0] v);
    @(negedge clk);
    srcLevel[core*NS +: NS] = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pins(input int core);
    return 32'(coreIrq[core*NP +: NP]);
  endfunction

  task automatic tReset();
    logic [31:0] d;
    rstN = 1'b0;
    srcLevel = '1;
    #2;
    check("R3 irq low in reset", 32'(coreIrq), 32'h0);
    doReset();
    busRead(1, 0, 4'd2, d); check("R3 mask zero", d, 32'h0);
    busRead(1, 0, 4'd1, d); check("R3 pend zero", d, 32'h0);
    busRead(2, 0, 4'd9, d); check("R3 map zero", d, 32'h0);
    busRead(3, 0, 4'd5, d); check("R3 sel zero", d, 32'h0);
  endtask

  task automatic tPending();
    logic [31:0] d;
    doReset();
    setSrc(1, 7'b1010101);
    busRead(1, 0, 4'd1, d); check("R1 pend order", d, 32'h55);
    check("R4 masked gives no pin", pins(1), 32'h0);
    busRead(0, 0, 4'd1, d); check("R1 other core pend", d, 32'h0);
  endtask

  task automatic tMask();
    logic [31:0] d;
    doReset();
    busWrite(1, 0, 4'd3, 32'h0F);
    busRead(1, 0, 4'd2, d); check("R2 set", d, 32'h0F);
    busWrite(1, 0, 4'd4, 32'h05);
    busRead(1, 0, 4'd2, d); check("R2 clear", d, 32'h0A);
    busWrite(1, 0, 4'd3, 32'h00);
    busRead(1, 0, 4'd2, d); check("R2 zero set no effect", d, 32'h0A);
    busWrite(1, 0, 4'd4, 32'h00);
    busRead(1, 0, 4'd2, d); check("R2 zero clear no effect", d, 32'h0A);
  endtask

  task automatic tRoute();
    logic [31:0] d;
    doReset();
    routeStrap[2*4 +: 4] = 4'hF;
    busWrite(2, 0, 4'd8, 32'h8000_0003);
    busWrite(2, 0, 4'd9, 32'h8000_0003);
    busWrite(2, 0, 4'd3, 32'h03);
    setSrc(2, 7'b0000001);
    check("R4 single source to pin3", pins(2), 32'h08);
    setSrc(2, 7'b0000011);
    check("R4 two sources OR", pins(2), 32'h08);
    busWrite(2, 0, 4'd4, 32'h01);
    check("R4 other source holds pin", pins(2), 32'h08);
    busWrite(2, 0, 4'd9, 32'h0000_0003);
    check("R5 valid clear drives nothing", pins(2), 32'h0);
    busWrite(2, 0, 4'd9, 32'h8000_0007);
    check("R5 pin out of range", pins(2), 32'h0);
    busWrite(2, 0, 4'd9, 32'h8000_0005);
    check("R5 pin5", pins(2), 32'h20);
    busRead(2, 0, 4'd9, d); check("R5 map readback", d, 32'h8000_0005);
    setSrc(2, 7'b0000000);
    check("R4 source drop", pins(2), 32'h0);
    routeStrap = '0;
  endtask

  task automatic tFixed();
    logic [31:0] d;
    doReset();
    routeStrap[3*4 +: 4] = 4'b0000;
    busWrite(3, 0, 4'd10, 32'h8000_0004);
    busWrite(3, 0, 4'd13, 32'h8000_0005);
    busWrite(3, 0, 4'd8, 32'h8000_0002);
    busWrite(3, 0, 4'd3, 32'h25);
    setSrc(3, 7'b0000100);
    check("R7 timer to default pin", pins(3), 32'h01);
    busRead(3, 0, 4'd0, d); check("R6 ctl zero", d, 32'h0);
    @(negedge clk); routeStrap[3*4 +: 4] = 4'b0001; #1;
    check("R6 timer strap routes", pins(3), 32'h10);
    busRead(3, 0, 4'd0, d); check("R6 ctl timer", d, 32'h1);
    setSrc(3, 7'b0100000);
    check("R7 sw1 default pin", pins(3), 32'h01);
    @(negedge clk); routeStrap[3*4 +: 4] = 4'b1001; #1;
    check("R6 sw pair strap", pins(3), 32'h20);
    busRead(3, 0, 4'd10, d); check("R7 map kept", d, 32'h8000_0004);
    @(negedge clk); routeStrap[3*4 +: 4] = 4'b0000;
    setSrc(3, 7'b0000001);
    check("R6 watchdog always routable", pins(3), 32'h04);
    routeStrap = '0;
  endtask

  task automatic tWindow();
    logic [31:0] d;
    doReset();
    routeStrap[2*4 +: 4] = 4'b0110;
    busWrite(0, 0, 4'd5, 32'h2);
    busRead(0, 0, 4'd5, d); check("R8 sel write", d, 32'h2);
    busWrite(0, 1, 4'd3, 32'h40);
    busRead(2, 0, 4'd2, d); check("R8 remote mask set", d, 32'h40);
    busRead(0, 0, 4'd2, d); check("R8 issuer untouched", d, 32'h0);
    busWrite(0, 1, 4'd11, 32'h8000_0001);
    busRead(2, 0, 4'd11, d); check("R8 remote map", d, 32'h8000_0001);
    busRead(0, 1, 4'd0, d); check("R8 remote ctl", d, 32'h6);
    busWrite(0, 1, 4'd5, 32'h3);
    busRead(2, 0, 4'd5, d); check("R8 remote sel write ignored", d, 32'h0);
    busRead(0, 0, 4'd5, d); check("R8 issuer sel kept", d, 32'h2);
    busRead(0, 1, 4'd5, d); check("R8 remote sel reads zero", d, 32'h0);
    busWrite(1, 1, 4'd3, 32'h01);
    busRead(0, 0, 4'd2, d); check("R8 default sel targets core0", d, 32'h01);
    routeStrap = '0;
  endtask

  task automatic tUnused();
    logic [31:0] d;
    doReset();
    busWrite(1, 0, 4'd3, 32'h7F);
    busRead(1, 0, 4'd6, d);  check("R9 addr6", d, 32'h0);
    busRead(1, 0, 4'd7, d);  check("R9 addr7", d, 32'h0);
    busRead(1, 0, 4'd15, d); check("R9 addr15", d, 32'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tPending();
    tMask();
    tRoute();
    tFixed();
    tWindow();
    tUnused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule